// File: doc/BRIEF.md
# Triggered Nibble Output Port

This block drives a group of output pins from a latch that changes only when a hardware trigger pulse arrives. Software uses a small register bus to stage the next pin pattern in a buffer built from 4-bit nibbles. Each nibble has its own bus address. A one-cycle trigger pulse then copies the staged pattern into the output latch. The pins can therefore change at a time set by hardware, however late the software wrote the buffer.

The port runs in one of two layouts. In split layout, each nibble is its own channel, with its own write address and its own trigger. In joint layout, the nibbles form one byte-wide channel: a write to any nibble address loads the whole byte, and the lowest trigger copies the whole byte. A per-pin selection mask, held in a register at the address just past the buffer, decides which pins follow the latch. The other pins follow a plain port data input. Buffer reads come back masked, so a pin under plain port control always reads as zero.

Top module: `rtout_port`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, the buffer, the output latch and the selection mask are all zero. Every pin then equals `port_data`, and a buffer read returns 0x00.
- R2: In split layout (`joint_mode`=0), a write to address 0xFF84 loads `bus_wdata[3:0]` into buffer bits 3:0 and leaves buffer bits 7:4 unchanged.
- R3: In split layout, a write to address 0xFF85 loads `bus_wdata[7:4]` into buffer bits 7:4 and leaves buffer bits 3:0 unchanged.
- R4: In joint layout (`joint_mode`=1), a write to 0xFF84 or to 0xFF85 loads all 8 bits of `bus_wdata` into the buffer.
- R5: A read from 0xFF84 or from 0xFF85 returns the whole buffer, bits 7:4 then bits 3:0, in either layout. Each bit whose mask bit is 0 reads as 0.
- R6: In split layout, `rt_trig[0]` high at a clock edge copies buffer bits 3:0 into latch bits 3:0, and `rt_trig[1]` copies bits 7:4 into latch bits 7:4. A latch nibble whose trigger is low keeps its value.
- R7: In joint layout, `rt_trig[0]` copies all 8 buffer bits into the latch, and `rt_trig[1]` has no effect.
- R8: Each pin `pin_out[i]` equals latch bit i when mask bit i is 1, and equals `port_data[i]` when mask bit i is 0.
- R9: When a buffer write and a trigger occur in the same cycle, the latch takes the buffer value from before the write, and the buffer takes the new data.
- R10: A write to 0xFF86 loads the selection mask, and a read from 0xFF86 returns it. Any other address reads as 0x00, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational from `bus_addr` |
| rt_trig | input | 2 | Trigger pulses, bit 0 for the low nibble and bit 1 for the high nibble |
| joint_mode | input | 1 | 0 = two 4-bit channels, 1 = one 8-bit channel |
| port_data | input | 8 | Plain port data for pins whose mask bit is 0 |
| pin_out | output | 8 | Output pins |

## Verification
A corrupted buffer nibble shows up at once on a masked read from either buffer address. It reaches the pins one edge after the next trigger for that nibble. A latch nibble that is copied at the wrong time, or from the wrong source, changes the pins on the edge itself, so the bench checks pins and read data in every cycle against a model. Same-cycle write and trigger, and triggers from the wrong nibble in joint layout, are the cases that expose a latch fed from post-write data or enabled by the wrong trigger.

// File: rtl/rtout_pkg.sv
package rtout_pkg;
  typedef enum logic {
    LAYOUT_SPLIT = 1'b0,
    LAYOUT_JOINT = 1'b1
  } rt_layout_e;

  localparam int unsigned DEF_NIB_W   = 4;
  localparam int unsigned DEF_NUM_NIB = 2;
  localparam int unsigned DEF_ADDR_W  = 16;
endpackage

// File: rtl/rtout_rst_sync.sv
module rtout_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtout_buf.sv
module rtout_buf
  import rtout_pkg::*;
#(
  parameter int unsigned   NIB_W     = DEF_NIB_W,
  parameter int unsigned   NUM_NIB   = DEF_NUM_NIB,
  parameter int unsigned   ADDR_W    = DEF_ADDR_W,
  parameter logic [15:0]   BASE_ADDR = 16'hFF84,
  parameter logic [15:0]   MASK_ADDR = 16'hFF86,
  localparam int unsigned  DATA_W    = NIB_W * NUM_NIB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  rt_layout_e        layout,
  output logic [DATA_W-1:0] buf_q,
  output logic [DATA_W-1:0] mask_q
);
  logic [NUM_NIB-1:0] nib_hit;
  logic [NUM_NIB-1:0] nib_en;
  logic [DATA_W-1:0]  buf_d;
  logic [DATA_W-1:0]  mask_d;
  logic               mask_en;

  for (genvar gi = 0; gi < NUM_NIB; gi++) begin : g_nib
    assign nib_hit[gi] = bus_wr && (bus_addr == ADDR_W'(BASE_ADDR + gi));
    assign nib_en[gi]  = (layout == LAYOUT_JOINT) ? (|nib_hit) : nib_hit[gi];

    always_comb begin
      buf_d[gi*NIB_W +: NIB_W] = buf_q[gi*NIB_W +: NIB_W];
      if (nib_en[gi]) buf_d[gi*NIB_W +: NIB_W] = bus_wdata[gi*NIB_W +: NIB_W];
    end
  end

  assign mask_en = bus_wr && (bus_addr == ADDR_W'(MASK_ADDR));

  always_comb begin
    mask_d = mask_q;
    if (mask_en) mask_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      mask_q <= '0;
    end else begin
      buf_q  <= buf_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/rtout_latch.sv
module rtout_latch
  import rtout_pkg::*;
#(
  parameter int unsigned  NIB_W   = DEF_NIB_W,
  parameter int unsigned  NUM_NIB = DEF_NUM_NIB,
  localparam int unsigned DATA_W  = NIB_W * NUM_NIB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_NIB-1:0] trig,
  input  rt_layout_e         layout,
  input  logic [DATA_W-1:0]  buf_q,
  output logic [DATA_W-1:0]  lat_q
);
  logic [NUM_NIB-1:0] copy_en;
  logic [DATA_W-1:0]  lat_d;

  for (genvar gi = 0; gi < NUM_NIB; gi++) begin : g_nib
    assign copy_en[gi] = (layout == LAYOUT_JOINT) ? trig[0] : trig[gi];

    always_comb begin
      lat_d[gi*NIB_W +: NIB_W] = lat_q[gi*NIB_W +: NIB_W];
      if (copy_en[gi]) lat_d[gi*NIB_W +: NIB_W] = buf_q[gi*NIB_W +: NIB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end
endmodule

// File: rtl/rtout_port.sv
module rtout_port
  import rtout_pkg::*;
#(
  parameter int unsigned  NIB_W     = DEF_NIB_W,
  parameter int unsigned  NUM_NIB   = DEF_NUM_NIB,
  parameter int unsigned  ADDR_W    = DEF_ADDR_W,
  parameter logic [15:0]  BASE_ADDR = 16'hFF84,
  parameter logic [15:0]  MASK_ADDR = 16'hFF86,
  localparam int unsigned DATA_W    = NIB_W * NUM_NIB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_NIB-1:0] rt_trig,
  input  logic               joint_mode,
  input  logic [DATA_W-1:0]  port_data,
  output logic [DATA_W-1:0]  pin_out
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] lat_q;
  rt_layout_e        layout;
  logic              buf_sel;

  assign layout = rt_layout_e'(joint_mode);

  rtout_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rtout_buf #(
    .NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .layout    (layout),
    .buf_q     (buf_q),
    .mask_q    (mask_q)
  );

  rtout_latch #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_lat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .trig   (rt_trig),
    .layout (layout),
    .buf_q  (buf_q),
    .lat_q  (lat_q)
  );

  assign buf_sel = (bus_addr >= ADDR_W'(BASE_ADDR)) &&
                   (bus_addr <  ADDR_W'(BASE_ADDR + NUM_NIB));

  always_comb begin
    if (buf_sel)                            bus_rdata = buf_q & mask_q;
    else if (bus_addr == ADDR_W'(MASK_ADDR)) bus_rdata = mask_q;
    else                                    bus_rdata = '0;
  end

  for (genvar gb = 0; gb < DATA_W; gb++) begin : g_pin
    assign pin_out[gb] = mask_q[gb] ? lat_q[gb] : port_data[gb];
  end
endmodule

// File: rtl/rtout_port_chk.sv
module rtout_port_chk #(
  parameter int unsigned  NIB_W     = 4,
  parameter int unsigned  NUM_NIB   = 2,
  parameter int unsigned  ADDR_W    = 16,
  parameter logic [15:0]  BASE_ADDR = 16'hFF84,
  parameter logic [15:0]  MASK_ADDR = 16'hFF86,
  localparam int unsigned DATA_W    = NIB_W * NUM_NIB
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_sync_n,
  input logic               joint_mode,
  input logic [NUM_NIB-1:0] rt_trig,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  buf_q,
  input logic [DATA_W-1:0]  lat_q,
  input logic [DATA_W-1:0]  mask_q
);
  localparam logic [ADDR_W-1:0] TOP_NIB_ADDR = ADDR_W'(BASE_ADDR + NUM_NIB - 1);

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (buf_q == '0 && lat_q == '0 && mask_q == '0)); // R1

  AST_LO_BUF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && bus_wr && !joint_mode && bus_addr == TOP_NIB_ADDR)
      |=> $stable(buf_q[NIB_W-1:0])); // R3

  AST_LO_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !rt_trig[0]) |=> $stable(lat_q[NIB_W-1:0])); // R6

  AST_JOINT_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && joint_mode && !rt_trig[0]) |=> $stable(lat_q)); // R7

  AST_LAT_OLD_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && rt_trig[0]) |=> (lat_q[NIB_W-1:0] == $past(buf_q[NIB_W-1:0]))); // R9

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !(bus_wr && bus_addr == ADDR_W'(MASK_ADDR))) |=> $stable(mask_q)); // R10
endmodule

bind rtout_port rtout_port_chk #(
  .NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .ADDR_W(ADDR_W),
  .BASE_ADDR(BASE_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .joint_mode (joint_mode),
  .rt_trig    (rt_trig),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .buf_q      (buf_q),
  .lat_q      (lat_q),
  .mask_q     (mask_q)
);

// File: tb/rtout_port_test.sv
module rtout_port_test;
  localparam logic [15:0] A_LO   = 16'hFF84;
  localparam logic [15:0] A_HI   = 16'hFF85;
  localparam logic [15:0] A_MASK = 16'hFF86;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [1:0]  rt_trig;
  logic        joint_mode;
  logic [7:0]  port_data;
  logic [7:0]  pin_out;

  logic [7:0] m_buf, m_lat, m_mask;
  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rtout_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rt_trig(rt_trig),
    .joint_mode(joint_mode), .port_data(port_data), .pin_out(pin_out)
  );

  function automatic logic [7:0] f_read(logic [15:0] a, logic [7:0] b, logic [7:0] m);
    if (a == A_LO || a == A_HI) return b & m;
    if (a == A_MASK)            return m;
    return 8'h00;
  endfunction

  function automatic logic [7:0] f_pins(logic [7:0] l, logic [7:0] m, logic [7:0] pd);
    return (l & m) | (pd & ~m);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic [15:0] a, logic wr, logic [7:0] wd,
                      logic [1:0] tg, logic jm, logic [7:0] pd);
    logic [7:0] ob;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_wdata = wd;
    rt_trig = tg; joint_mode = jm; port_data = pd;
    #1;
    chk({req, " read"}, bus_rdata, f_read(a, m_buf, m_mask));
    chk({req, " pins"}, pin_out, f_pins(m_lat, m_mask, pd));
    @(posedge clk);
    ob = m_buf;
    if (wr) begin
      if (a == A_LO)   m_buf = jm ? wd : {m_buf[7:4], wd[3:0]};
      if (a == A_HI)   m_buf = jm ? wd : {wd[7:4], m_buf[3:0]};
      if (a == A_MASK) m_mask = wd;
    end
    if (jm) begin
      if (tg[0]) m_lat = ob;
    end else begin
      if (tg[0]) m_lat[3:0] = ob[3:0];
      if (tg[1]) m_lat[7:4] = ob[7:4];
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_wdata = '0;
    rt_trig = '0; joint_mode = 0; port_data = '0;
    m_buf = '0; m_lat = '0; m_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state, pins follow port_data, reads zero
    step("R1", A_LO,   0, 8'h00, 2'b00, 0, 8'hA7);
    step("R1", A_MASK, 0, 8'h00, 2'b00, 0, 8'h3C);
    // R10: mask register write and readback
    step("R10", A_MASK, 1, 8'hFF, 2'b00, 0, 8'h00);
    step("R10", A_MASK, 0, 8'h00, 2'b00, 0, 8'h00);
    chk("R10 mask readback", bus_rdata, 8'hFF);
    // R2: split write to low address
    step("R2", A_LO, 1, 8'hA5, 2'b00, 0, 8'h00);
    step("R2", A_LO, 0, 8'h00, 2'b00, 0, 8'h00);
    chk("R2 low nibble only", bus_rdata, 8'h05);
    // R3: split write to high address
    step("R3", A_HI, 1, 8'h3C, 2'b00, 0, 8'h00);
    step("R3", A_HI, 0, 8'h00, 2'b00, 0, 8'h00);
    chk("R3 high nibble only", bus_rdata, 8'h35);
    // R4: joint write via high address loads whole byte
    step("R4", A_HI, 1, 8'h96, 2'b00, 1, 8'h00);
    step("R4", A_LO, 0, 8'h00, 2'b00, 1, 8'h00);
    chk("R4 full byte", bus_rdata, 8'h96);
    // R5: masked read
    step("R5", A_MASK, 1, 8'h0F, 2'b00, 0, 8'h00);
    step("R5", A_HI,   0, 8'h00, 2'b00, 0, 8'h00);
    chk("R5 masked read", bus_rdata, 8'h06);
    step("R5", A_MASK, 1, 8'hFF, 2'b00, 0, 8'h00);
    // R6: split high trigger copies high nibble only
    step("R6", A_LO, 0, 8'h00, 2'b10, 0, 8'h00);
    step("R6", A_LO, 0, 8'h00, 2'b00, 0, 8'h00);
    chk("R6 high trigger", pin_out, 8'h90);
    // R7: joint, trig[1] ignored, trig[0] copies byte
    step("R7", A_LO, 1, 8'h5A, 2'b10, 1, 8'h00);
    step("R7", A_LO, 0, 8'h00, 2'b00, 1, 8'h00);
    chk("R7 trig1 ignored", pin_out, 8'h90);
    step("R7", A_LO, 0, 8'h00, 2'b01, 1, 8'h00);
    step("R7", A_LO, 0, 8'h00, 2'b00, 1, 8'h00);
    chk("R7 trig0 full copy", pin_out, 8'h5A);
    // R9: same-cycle write and trigger
    step("R9", A_LO, 1, 8'h11, 2'b01, 1, 8'h00);
    step("R9", A_LO, 0, 8'h00, 2'b00, 1, 8'h00);
    chk("R9 latch old", pin_out, 8'h5A);
    chk("R9 buffer new", bus_rdata, 8'h11);
    // R10: other address ignored
    step("R10", 16'hFF80, 1, 8'hEE, 2'b00, 0, 8'h00);
    step("R10", 16'hFF80, 0, 8'h00, 2'b00, 0, 8'h00);
    chk("R10 other addr", bus_rdata, 8'h00);
    step("R10", A_LO, 0, 8'h00, 2'b00, 0, 8'h00);
    chk("R10 buffer untouched", bus_rdata, 8'h11);
    // R8: pin mux with mixed mask
    step("R8", A_MASK, 1, 8'hC3, 2'b00, 0, 8'h00);
    step("R8", A_LO, 0, 8'h00, 2'b00, 0, 8'h3C);
    chk("R8 mixed mux", pin_out, 8'h7E);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      case ($urandom_range(0, 4))
        0, 1: a = A_LO;
        2:    a = A_HI;
        3:    a = A_MASK;
        default: a = 16'($urandom);
      endcase
      step("R5 R8 random", a, 1'($urandom), 8'($urandom), 2'($urandom),
           1'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule